// File: doc/BRIEF.md
# Gate Configuration Rule Checker

This block decides whether a stored list of logic-gate slots forms a legal single-assignment netlist. Each slot names a gate type, up to two source operands and a destination. An operand or destination is either one of the external ports or one of the internal scratch registers. A strobe starts a scan. The checker then steps through the slots one per cycle, reading each from an external configuration store through an address and data pair. The store answers combinationally in the same cycle.

The scan stops at the first non-empty slot that breaks a rule. When it stops, the block reports the index of that slot, a 3-bit error code and a separate flag for a reused destination. A one-cycle done pulse ends every scan, and the valid output is high only when every slot passed.

Registers follow dataflow discipline. A register must be written by an earlier slot before any slot reads it, and only one slot may write it. To enforce this, the checker keeps a bitmap of the registers written so far. The bitmap is cleared when a scan starts, and a slot's destination is added to it only after that slot has passed.

Top module: `gate_cfg_checker`

## Requirements
- R1: A slot word is {gate[14:12], src1[11:8], src2[7:4], dst[3:0]}. In an operand field, 0 means absent, 1 to 4 name ports, and 5 to 14 name registers 0 to 9. Gate codes are 0 none, 1 AND, 2 OR, 3 NOT, 4 XOR, 5 NAND, 6 BUF and 7 XNOR. An all-zero slot is empty and is skipped.
- R2: A start pulse seen while idle raises busy and reads slots 0 to 13 in order, one per cycle, on rd_addr. A start pulse seen while busy is ignored.
- R3: done is high for exactly one cycle. If the scan passes, done arrives 14 cycles after the start edge with valid=1, err_code=0 and err_reuse=0. If slot k fails, done arrives k+1 cycles after the start edge with valid=0 and bad_slot=k. The result holds until the next start.
- R4: A non-empty slot with gate code 0 fails with code 1.
- R5: A NOT or BUF slot fails with code 2 in any of these cases: src1 is present, src2 is absent, or dst is absent.
- R6: A slot of any other gate fails with code 3 if src1, src2 or dst is absent.
- R7: Two sources naming the same port or the same register fail with code 4.
- R8: A register destination equal to a register source fails with code 5. A port may serve as both a source and the destination of the same slot.
- R9: A register read by src1 that no earlier slot of the current scan wrote fails with code 6. The same case for src2 fails with code 7. The written-register record starts empty at each scan.
- R10: A register destination that an earlier slot already wrote sets err_reuse=1 with err_code=0.
- R11: The first failing slot is the one reported. Within a slot, the checks take precedence in the order R4, R5, R6, R7, R8, R9 (src1 before src2), R10.
- R12: After reset, busy, done, valid, bad_slot, err_code and err_reuse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when idle |
| rd_addr | output | 4 | Slot index presented to the configuration store |
| rd_data | input | 15 | Slot word returned for rd_addr in the same cycle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| valid | output | 1 | Every slot passed |
| bad_slot | output | 4 | Index of the first failing slot |
| err_code | output | 3 | Failure cause, 0 when none |
| err_reuse | output | 1 | Register destination written twice |

## Verification
The assertions assume that the store never returns operand code 15 while a scan is running, so every operand field is absent, a port or a register. They also assume that rd_data follows rd_addr within the cycle. The bench stores only codes built from named port and register constants, with unused slots left at zero, and it drives the store combinationally from rd_addr. Runs back to back reuse registers that earlier scans wrote, which shows that the written record does not carry over from one scan to the next.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
   localparam int GATE_W = 3;
   localparam int CODE_W = 3;

   localparam logic [GATE_W-1:0] GATE_NONE = 3'd0;
   localparam logic [GATE_W-1:0] GATE_AND  = 3'd1;
   localparam logic [GATE_W-1:0] GATE_OR   = 3'd2;
   localparam logic [GATE_W-1:0] GATE_NOT  = 3'd3;
   localparam logic [GATE_W-1:0] GATE_XOR  = 3'd4;
   localparam logic [GATE_W-1:0] GATE_NAND = 3'd5;
   localparam logic [GATE_W-1:0] GATE_BUF  = 3'd6;
   localparam logic [GATE_W-1:0] GATE_XNOR = 3'd7;

   typedef enum logic [CODE_W-1:0] {
      ERR_NONE      = 3'd0,
      ERR_NO_GATE   = 3'd1,
      ERR_UNARY     = 3'd2,
      ERR_BINARY    = 3'd3,
      ERR_SAME_SRC  = 3'd4,
      ERR_DST_CLASH = 3'd5,
      ERR_UNDEF_S1  = 3'd6,
      ERR_UNDEF_S2  = 3'd7
   } err_e;
endpackage

// File: rtl/gcc_opnd_dec.sv
module gcc_opnd_dec #(
   parameter int NUM_PORTS = 4,
   parameter int NUM_REGS  = 10,
   parameter int OPW       = 4
) (
   input  logic [OPW-1:0]      code,
   output logic                present,
   output logic                is_reg,
   output logic [NUM_REGS-1:0] reg_oh
);
   localparam logic [OPW-1:0] LAST_CODE = OPW'(NUM_PORTS + NUM_REGS);
   localparam logic [OPW-1:0] LAST_PORT = OPW'(NUM_PORTS);

   assign present = (code != '0) && (code <= LAST_CODE);
   assign is_reg  = (code > LAST_PORT) && (code <= LAST_CODE);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [OPW-1:0] MY_CODE = OPW'(NUM_PORTS + 1 + i);
      assign reg_oh[i] = (code == MY_CODE);
   end
endmodule

// File: rtl/gcc_slot_check.sv
module gcc_slot_check
   import gcc_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int NUM_REGS  = 10,
   parameter int OPW       = 4,
   parameter int SLOT_W    = GATE_W + 3*OPW
) (
   input  logic [SLOT_W-1:0]   word,
   input  logic [NUM_REGS-1:0] written,
   output logic                empty,
   output logic                ok,
   output err_e                code,
   output logic                reuse,
   output logic [NUM_REGS-1:0] rec_mask
);
   // field index: 0 = dst, 1 = src2, 2 = src1
   logic                fp  [3];
   logic                fr  [3];
   logic [NUM_REGS-1:0] foh [3];
   logic [OPW-1:0]      fc  [3];

   for (genvar k = 0; k < 3; k++) begin : g_fld
      assign fc[k] = word[k*OPW +: OPW];
      gcc_opnd_dec #(
         .NUM_PORTS (NUM_PORTS),
         .NUM_REGS  (NUM_REGS),
         .OPW       (OPW)
      ) u_dec (
         .code    (fc[k]),
         .present (fp[k]),
         .is_reg  (fr[k]),
         .reg_oh  (foh[k])
      );
   end

   logic [GATE_W-1:0] gate;
   logic              unary;
   assign gate  = word[SLOT_W-1 -: GATE_W];
   assign unary = (gate == GATE_NOT) || (gate == GATE_BUF);
   assign empty = (word == '0);

   always_comb begin
      code  = ERR_NONE;
      reuse = 1'b0;
      if (gate == GATE_NONE)
         code = ERR_NO_GATE;
      else if (unary && (fp[2] || !fp[1] || !fp[0]))
         code = ERR_UNARY;
      else if (!unary && (!fp[2] || !fp[1] || !fp[0]))
         code = ERR_BINARY;
      else if (fp[2] && fp[1] && (fc[2] == fc[1]))
         code = ERR_SAME_SRC;
      else if (fr[0] && ((fr[2] && fc[2] == fc[0]) || (fr[1] && fc[1] == fc[0])))
         code = ERR_DST_CLASH;
      else if (fr[2] && ((written & foh[2]) == '0))
         code = ERR_UNDEF_S1;
      else if (fr[1] && ((written & foh[1]) == '0))
         code = ERR_UNDEF_S2;
      else if (fr[0] && ((written & foh[0]) != '0))
         reuse = 1'b1;
   end

   assign ok       = empty || ((code == ERR_NONE) && !reuse);
   assign rec_mask = (!empty && fr[0]) ? foh[0] : '0;
endmodule

// File: rtl/gcc_reg_track.sv
module gcc_reg_track #(
   parameter int NUM_REGS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                commit,
   input  logic [NUM_REGS-1:0] mask,
   output logic [NUM_REGS-1:0] written
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         written <= '0;
      else if (clr)
         written <= '0;
      else if (commit)
         written <= written | mask;
   end

   assert_record_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (written == '0));

   assert_record_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> ((written & $past(written)) == $past(written)));
endmodule

// File: rtl/gcc_scan_ctrl.sv
module gcc_scan_ctrl
   import gcc_pkg::*;
#(
   parameter int NUM_SLOTS = 14,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             slot_ok,
   input  err_e             slot_code,
   input  logic             slot_reuse,
   output logic [IDX_W-1:0] idx,
   output logic             clr,
   output logic             commit,
   output logic             busy,
   output logic             done,
   output logic             valid,
   output logic [IDX_W-1:0] bad_slot,
   output err_e             err_code,
   output logic             err_reuse
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

   logic start_acc;
   assign start_acc = start && !busy;
   assign clr       = start_acc;
   assign commit    = busy && slot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         done      <= 1'b0;
         valid     <= 1'b0;
         bad_slot  <= '0;
         err_code  <= ERR_NONE;
         err_reuse <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_acc) begin
            busy      <= 1'b1;
            idx       <= '0;
            valid     <= 1'b0;
            bad_slot  <= '0;
            err_code  <= ERR_NONE;
            err_reuse <= 1'b0;
         end else if (busy) begin
            if (!slot_ok) begin
               busy      <= 1'b0;
               done      <= 1'b1;
               bad_slot  <= idx;
               err_code  <= slot_code;
               err_reuse <= slot_reuse;
            end else if (idx == LAST_IDX) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               valid <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assert_addr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (idx == $past(idx) + 1'b1));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_pass_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && valid) |-> (err_code == ERR_NONE && !err_reuse));

   assert_fail_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !valid) |-> (err_code != ERR_NONE || err_reuse));
endmodule

// File: rtl/gate_cfg_checker.sv
module gate_cfg_checker
   import gcc_pkg::*;
#(
   parameter int NUM_SLOTS = 14,
   parameter int NUM_PORTS = 4,
   parameter int NUM_REGS  = 10,
   parameter int OPW       = $clog2(NUM_PORTS + NUM_REGS + 1),
   parameter int IDX_W     = $clog2(NUM_SLOTS),
   parameter int SLOT_W    = GATE_W + 3*OPW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [IDX_W-1:0]  rd_addr,
   input  logic [SLOT_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              valid,
   output logic [IDX_W-1:0]  bad_slot,
   output logic [2:0]        err_code,
   output logic              err_reuse
);
   localparam logic [OPW-1:0] LAST_CODE = OPW'(NUM_PORTS + NUM_REGS);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("gate_cfg_checker: NUM_SLOTS must be at least 2");
   end
   if (NUM_PORTS < 1 || NUM_REGS < 1) begin : g_bad_opnd
      $error("gate_cfg_checker: need at least one port and one register");
   end
   if ((1 << OPW) < NUM_PORTS + NUM_REGS + 1) begin : g_bad_opw
      $error("gate_cfg_checker: OPW too narrow for operand codes");
   end

   logic [NUM_REGS-1:0] written, rec_mask;
   logic                slot_empty, slot_ok, slot_reuse;
   err_e                slot_code, code_q;
   logic                clr, commit;

   gcc_slot_check #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_REGS  (NUM_REGS),
      .OPW       (OPW),
      .SLOT_W    (SLOT_W)
   ) u_check (
      .word     (rd_data),
      .written  (written),
      .empty    (slot_empty),
      .ok       (slot_ok),
      .code     (slot_code),
      .reuse    (slot_reuse),
      .rec_mask (rec_mask)
   );

   gcc_reg_track #(
      .NUM_REGS (NUM_REGS)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .commit  (commit),
      .mask    (rec_mask),
      .written (written)
   );

   gcc_scan_ctrl #(
      .NUM_SLOTS (NUM_SLOTS),
      .IDX_W     (IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .slot_ok    (slot_ok),
      .slot_code  (slot_code),
      .slot_reuse (slot_reuse),
      .idx        (rd_addr),
      .clr        (clr),
      .commit     (commit),
      .busy       (busy),
      .done       (done),
      .valid      (valid),
      .bad_slot   (bad_slot),
      .err_code   (code_q),
      .err_reuse  (err_reuse)
   );

   assign err_code = code_q;

   assert_operand_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_data[OPW-1:0] <= LAST_CODE &&
                rd_data[2*OPW-1:OPW] <= LAST_CODE &&
                rd_data[3*OPW-1:2*OPW] <= LAST_CODE));

   assert_empty_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && slot_empty) |=> (!done || valid || bad_slot != $past(rd_addr)));
endmodule

// File: tb/sim_gate_cfg_checker.sv
module sim_gate_cfg_checker;
   localparam int NS = 14;

   localparam int G_AND = 1, G_OR = 2, G_NOT = 3, G_XOR = 4;
   localparam int G_NAND = 5, G_BUF = 6, G_XNOR = 7;
   localparam int PA = 1, PB = 2, PC = 3, PD = 4;

   function automatic logic [14:0] w(int g, int s1, int s2, int d);
      return {g[2:0], s1[3:0], s2[3:0], d[3:0]};
   endfunction
   function automatic int r(int n);
      return 5 + n;
   endfunction

   typedef struct packed {
      logic [3:0]  pa; logic [14:0] wa;
      logic [3:0]  pb; logic [14:0] wb;
      logic [3:0]  pc; logic [14:0] wc;
      logic        ev; logic [3:0]  es; logic [2:0] ec; logic er;
   } case_t;

   localparam int NCASE = 16;
   localparam case_t CASES [NCASE] = '{
      '{15, 0, 15, 0, 15, 0, 1, 0, 0, 0},                                                    // R1 all empty
      '{0, w(G_AND,PA,PB,r(0)), 1, w(G_OR,r(0),PC,PD), 6, w(G_BUF,0,r(0),r(5)), 1, 0, 0, 0},  // R1 legal chain
      '{3, w(0,PA,0,0), 15, 0, 15, 0, 0, 3, 1, 0},                                           // R4
      '{0, w(G_NOT,PA,PB,PC), 15, 0, 15, 0, 0, 0, 2, 0},                                     // R5
      '{2, w(G_XOR,PA,0,PC), 15, 0, 15, 0, 0, 2, 3, 0},                                      // R6
      '{0, w(G_AND,PA,PA,PB), 15, 0, 15, 0, 0, 0, 4, 0},                                     // R7 ports
      '{0, w(G_AND,PA,PB,PA), 1, w(G_NOT,0,PC,PC), 15, 0, 1, 0, 0, 0},                       // R8 port alias ok
      '{0, w(G_AND,PA,PB,r(1)), 1, w(G_NAND,r(1),PC,r(1)), 15, 0, 0, 1, 5, 0},               // R8 clash
      '{0, w(G_AND,PA,PB,r(2)), 1, w(G_XOR,r(2),r(2),PC), 15, 0, 0, 1, 4, 0},                // R7 regs
      '{4, w(G_AND,r(2),PA,PB), 15, 0, 15, 0, 0, 4, 6, 0},                                   // R9 cleared
      '{0, w(G_AND,PA,PB,r(0)), 1, w(G_AND,PA,r(3),PC), 15, 0, 0, 1, 7, 0},                  // R9 src2
      '{0, w(G_BUF,0,PA,r(9)), 5, w(G_AND,PA,PB,r(9)), 15, 0, 0, 5, 0, 1},                   // R10
      '{2, w(0,PA,0,0), 7, w(G_AND,PA,PA,PB), 15, 0, 0, 2, 1, 0},                            // R11 first slot
      '{13, w(G_XNOR,r(0),PA,PB), 15, 0, 15, 0, 0, 13, 6, 0},                                // R3 last slot
      '{0, w(G_AND,r(1),r(1),r(1)), 15, 0, 15, 0, 0, 0, 4, 0},                               // R11 order
      '{0, w(G_BUF,0,PA,r(3)), 1, w(G_AND,r(6),PB,r(3)), 15, 0, 0, 1, 6, 0}                  // R11 undef over reuse
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  rd_addr;
   logic [14:0] rd_data;
   logic        busy, done, valid, err_reuse;
   logic [3:0]  bad_slot;
   logic [2:0]  err_code;
   logic [14:0] store [16];

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   assign rd_data = store[rd_addr];

   gate_cfg_checker u0 (
      .clk (clk), .rst_n (rst_n), .start (start),
      .rd_addr (rd_addr), .rd_data (rd_data),
      .busy (busy), .done (done), .valid (valid),
      .bad_slot (bad_slot), .err_code (err_code), .err_reuse (err_reuse)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load(case_t c);
      for (int i = 0; i < 16; i++) store[i] = '0;
      store[c.pa] = c.wa;
      store[c.pb] = c.wb;
      store[c.pc] = c.wc;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int lat;
      for (int i = 0; i < 16; i++) store[i] = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 busy", int'(busy), 0);
      check("R12 done", int'(done), 0);
      check("R12 valid", int'(valid), 0);
      check("R12 bad_slot", int'(bad_slot), 0);
      check("R12 err_code", int'(err_code), 0);
      check("R12 err_reuse", int'(err_reuse), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NCASE; n++) begin
         case_t c;
         c = CASES[n];
         load(c);
         pulse_start();
         check("R2 busy after start", int'(busy), 1);
         wait_done(lat);
         check("R3 latency", lat, c.ev ? NS : int'(c.es) + 1);
         check("R3 valid", int'(valid), int'(c.ev));
         check("R11 bad_slot", int'(bad_slot), int'(c.es));
         check("R4-code err_code", int'(err_code), int'(c.ec));
         check("R10 err_reuse", int'(err_reuse), int'(c.er));
         @(negedge clk);
         check("R3 done single", int'(done), 0);
         check("R3 result held", int'(valid), int'(c.ev));
         check("R2 idle after done", int'(busy), 0);
      end

      // R2 start while busy is ignored
      load(CASES[1]);
      pulse_start();
      repeat (4) @(negedge clk);
      pulse_start();
      lat = 5;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check("R2 restart ignored latency", lat, NS);
      check("R2 restart ignored valid", int'(valid), 1);

      // R9 record cleared: previous scan wrote register 0
      load(CASES[13]);
      pulse_start();
      wait_done(lat);
      check("R9 cleared code", int'(err_code), 6);
      check("R9 cleared slot", int'(bad_slot), 13);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule